// File: doc/BRIEF.md
# Idle-Launched Nonvolatile Memory Operation Sequencer

This block carries out erase, byte-program and byte-read operations on two on-chip nonvolatile banks: a 64 KB application bank and a 4 KB loader bank. Software first writes four byte registers: the low and high halves of a 16-bit target address, a data byte and a command byte. It then puts the processor into idle. Entering idle is the launch trigger. If programming is enabled and the command byte is a legal operation, the sequencer drives a simple memory port, times the operation in clock cycles and raises a busy flag while it runs. A wake-up interrupt ends idle. A wake-up that arrives while the operation is still busy is held off until the operation has finished.

The command byte holds a bank select, an output-enable bit, a chip-enable bit and a 4-bit operation code. Programming can only clear bits: the sequencer reads the old byte and writes back the old byte AND the data byte. A read places the byte in the data register, unless the lock input is active. In that case the data register receives 00H and the array is not touched. Operation lengths are parameters in clock cycles, so a simulation can scale them down.

Top module: `flash_seq_top`

## Requirements
- R1: After reset, busy and idle_active are 0 and all four registers (offset 0 address low, 1 address high, 2 data, 3 command) read 00H.
- R2: A register write at offsets 0 to 3 is stored and read back combinationally through reg_rdata at the same offset.
- R3: On an idle_enter pulse while not in idle, idle_active rises on the next edge. With prog_en=1 and a legal command, busy also rises on that edge and stays high for exactly the parameter cycle count of that operation (ERASE_CYC, PROG_CYC or READ_CYC).
- R4: Command bit 6 selects the bank (0 application, 1 loader), bit 5 is output enable, bit 4 is chip enable and bits 3:0 are the operation code. Bit 7 must be 0. Code 0010 with output enable 1 and chip enable 0 (22H for the application bank) issues one whole-bank erase strobe, after which every location of that bank reads FFH and the other bank is unchanged.
- R5: Code 0001 with output enable 1 and chip enable 0 (21H) reads the addressed byte and writes back the old byte AND the data register, so a second program of the same address can only clear more bits.
- R6: Code 0000 with output enable 0 and chip enable 0 (00H) loads the addressed byte into the data register. An erased location returns FFH.
- R7: With prog_en=0, or with any other command byte, entering idle makes no memory access, keeps busy at 0 and leaves the array and the data register unchanged.
- R8: idle_active falls one edge after wake_req is seen with busy low. While busy is high, wake_req does not end idle.
- R9: For the loader bank, mem_bank is 1 and the address bits above bit 11 are driven as 0, so the address wraps within 4 KB.
- R10: A read with lock_n=0 makes no array access and loads 00H into the data register.
- R11: Register writes while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset (0 addr low, 1 addr high, 2 data, 3 command) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at reg_addr |
| idle_enter | input | 1 | One-cycle strobe: processor enters idle |
| wake_req | input | 1 | Wake-up interrupt request, held until idle ends |
| prog_en | input | 1 | Programming enable; 0 makes the banks read-only |
| lock_n | input | 1 | Read lock, active low |
| idle_active | output | 1 | Processor held in idle |
| busy | output | 1 | Operation in progress |
| mem_rd | output | 1 | Array read strobe (data valid next cycle) |
| mem_wr | output | 1 | Array byte write strobe |
| mem_erase | output | 1 | Whole-bank erase strobe |
| mem_bank | output | 1 | Bank select, 1 = loader bank |
| mem_addr | output | 16 | Array byte address |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, registered one cycle after mem_rd |

## Verification
Directed sequences cover these cases: a read of an erased cell, then a program, then a second program with overlapping bits. The second program can only pass if the AND with the old contents is applied and not a plain overwrite. A loader-bank program with a high address checks the 12-bit wrap, and an erase run afterwards checks that only the selected bank is cleared. Disabled, illegal and locked commands are compared against a count of memory strobes, which separates an operation that was suppressed from one that only returned the right value. Random program and read operations over a small address pool in both banks, compared with a bench model, exercise repeated bit clearing and crosstalk between the banks.

// File: rtl/flash_seq_pkg.sv
// Shared types for the idle-launched flash sequencer.
// Assumes the command byte layout described in the brief.
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROG  = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    // Decode a command byte into an operation; anything not legal is OP_NONE.
    function automatic op_e decode_cmd(input logic [7:0] c);
        op_e r;
        case ({c[7], c[5], c[4], c[3:0]})
            7'b0_1_0_0010: r = OP_ERASE;
            7'b0_1_0_0001: r = OP_PROG;
            7'b0_0_0_0000: r = OP_READ;
            default:       r = OP_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
// Command decoder: turns the command byte plus the programming enable
// into an operation and a bank select. Purely combinational.
module flash_cmd_decode
    import flash_seq_pkg::*;
(
    input  logic [7:0] cmd,
    input  logic       prog_en,
    output op_e        op,
    output logic       bank
);
    // Gate the decoded operation with the programming enable.
    always_comb begin
        op   = prog_en ? decode_cmd(cmd) : OP_NONE;
        bank = cmd[6];
    end
endmodule

// File: rtl/flash_op_timer.sv
// Operation timer: holds busy for exactly dur cycles after start and
// flags the first two busy cycles for the memory access steps.
// Assumes dur >= 3 and that start is never raised while busy.
module flash_op_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] dur,
    output logic             busy,
    output logic             step0,
    output logic             step1
);
    logic [CNT_W-1:0] cnt;
    logic [1:0]       step;

    // Down-count the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= dur - 1'b1;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // Saturating step index within the operation.
    always_ff @(posedge clk) begin
        if (!rst_n)                       step <= 2'd0;
        else if (start)                   step <= 2'd0;
        else if (busy && step != 2'd2)    step <= step + 2'd1;
    end

    // Step strobes are valid only while busy.
    always_comb begin
        step0 = busy && (step == 2'd0);
        step1 = busy && (step == 2'd1);
    end
endmodule

// File: rtl/flash_reg_file.sv
// Byte register file: address low/high, data and command.
// Software writes are ignored while an operation is busy; the sequencer
// may load the data register with a read result.
module flash_reg_file #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wdata,
    input  logic [1:0]        rd_addr,
    output logic [7:0]        rdata,
    input  logic              busy,
    input  logic              load_en,
    input  logic [7:0]        load_val,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        data_q,
    output logic [7:0]        cmd_q
);
    logic [7:0] addr_lo, addr_hi;

    // Hold the four registers; the read result takes priority over software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo <= '0;
            addr_hi <= '0;
            data_q  <= '0;
            cmd_q   <= '0;
        end else if (load_en) begin
            data_q <= load_val;
        end else if (wr_en && !busy) begin
            case (wr_addr)
                2'd0: addr_lo <= wdata;
                2'd1: addr_hi <= wdata;
                2'd2: data_q  <= wdata;
                default: cmd_q <= wdata;
            endcase
        end
    end

    // Combinational read-back mux and address assembly.
    always_comb begin
        case (rd_addr)
            2'd0: rdata = addr_lo;
            2'd1: rdata = addr_hi;
            2'd2: rdata = data_q;
            default: rdata = cmd_q;
        endcase
        addr_q = ADDR_W'({addr_hi, addr_lo});
    end
endmodule

// File: rtl/flash_seq_top.sv
// Idle-launched flash operation sequencer. Entering idle launches the
// latched command; a wake-up ends idle but is held off while busy.
// Assumes the array returns read data one cycle after mem_rd and that
// every duration parameter is at least 3.
module flash_seq_top
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LDR_ADDR_W = 12,
    parameter int ERASE_CYC  = 3750000,
    parameter int PROG_CYC   = 12500,
    parameter int READ_CYC   = 375
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              idle_enter,
    input  logic              wake_req,
    input  logic              prog_en,
    input  logic              lock_n,
    output logic              idle_active,
    output logic              busy,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_erase,
    output logic              mem_bank,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int MAX_PR  = (PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC;
    localparam int MAX_CYC = (ERASE_CYC > MAX_PR) ? ERASE_CYC : MAX_PR;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q, cmd_q;
    op_e               op_d, op_q;
    logic              bank_d, bank_q;
    logic              launch, start, step0, step1, load_en;
    logic [7:0]        load_val;
    logic [CNT_W-1:0]  dur;

    flash_reg_file #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_addr(reg_addr), .wdata(reg_wdata),
        .rd_addr(reg_addr), .rdata(reg_rdata),
        .busy(busy), .load_en(load_en), .load_val(load_val),
        .addr_q(addr_q), .data_q(data_q), .cmd_q(cmd_q)
    );

    flash_cmd_decode u_dec (
        .cmd(cmd_q), .prog_en(prog_en), .op(op_d), .bank(bank_d)
    );

    flash_op_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .dur(dur),
        .busy(busy), .step0(step0), .step1(step1)
    );

    // Launch on idle entry; only a legal, enabled command starts the timer.
    always_comb begin
        launch = idle_enter && !idle_active && !busy;
        start  = launch && (op_d != OP_NONE);
        case (op_d)
            OP_ERASE: dur = CNT_W'(ERASE_CYC);
            OP_PROG:  dur = CNT_W'(PROG_CYC);
            default:  dur = CNT_W'(READ_CYC);
        endcase
    end

    // Latch the operation and bank for the duration of the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            bank_q <= 1'b0;
        end else if (start) begin
            op_q   <= op_d;
            bank_q <= bank_d;
        end
    end

    // Idle state: set on entry, cleared by wake-up only when not busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                idle_active <= 1'b0;
        else if (launch)           idle_active <= 1'b1;
        else if (wake_req && !busy) idle_active <= 1'b0;
    end

    // Memory port strobes and the read result path.
    always_comb begin
        mem_erase = step0 && (op_q == OP_ERASE);
        mem_rd    = step0 && ((op_q == OP_PROG) || ((op_q == OP_READ) && lock_n));
        mem_wr    = step1 && (op_q == OP_PROG);
        mem_wdata = mem_rdata & data_q;
        mem_bank  = bank_q;
        mem_addr  = bank_q ? {{(ADDR_W-LDR_ADDR_W){1'b0}}, addr_q[LDR_ADDR_W-1:0]}
                           : addr_q;
        load_en   = step1 && (op_q == OP_READ);
        load_val  = lock_n ? mem_rdata : 8'h00;
    end
endmodule

// File: rtl/flash_seq_checker.sv
// Assertion checker for flash_seq_top, attached with bind below.
// Assumes the same parameters as the top it is bound to.
module flash_seq_checker #(
    parameter int ADDR_W     = 16,
    parameter int LDR_ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              idle_enter,
    input logic              busy,
    input logic              idle_active,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_erase,
    input logic              mem_bank,
    input logic [ADDR_W-1:0] mem_addr
);
    a_r3_busy_within_idle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> idle_active);

    a_r3_start_from_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(idle_enter));

    a_r7_no_access_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd || mem_wr || mem_erase));

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, mem_erase}));

    a_r8_wake_held_off: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> idle_active);

    a_r9_loader_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_bank && (mem_rd || mem_wr)) |-> (mem_addr[ADDR_W-1:LDR_ADDR_W] == '0));
endmodule

bind flash_seq_top flash_seq_checker #(.ADDR_W(ADDR_W), .LDR_ADDR_W(LDR_ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .idle_enter(idle_enter), .busy(busy),
    .idle_active(idle_active), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_erase(mem_erase), .mem_bank(mem_bank), .mem_addr(mem_addr)
);

// File: tb/tb_flash_seq_top.sv
module tb_flash_seq_top;
    localparam int EC = 40, PC = 10, RC = 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'h00, reg_rdata;
    logic        idle_enter = 1'b0, wake_req = 1'b0, prog_en = 1'b1, lock_n = 1'b1;
    logic        idle_active, busy, mem_rd, mem_wr, mem_erase, mem_bank;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    int checks = 0, fails = 0, acc_cnt = 0;
    logic [7:0]  flash [int];
    logic [7:0]  model [int];
    logic [15:0] last_wr_addr;
    logic        last_wr_bank;

    always #2 clk = ~clk;

    flash_seq_top #(.ERASE_CYC(EC), .PROG_CYC(PC), .READ_CYC(RC)) dut (.*);

    // Behavioural array: registered read, byte write, whole-bank erase.
    always @(posedge clk) begin
        int k;
        k = {15'd0, mem_bank, mem_addr};
        if (mem_rd || mem_wr || mem_erase) acc_cnt++;
        if (mem_rd) mem_rdata <= flash.exists(k) ? flash[k] : 8'hFF;
        if (mem_wr) begin
            flash[k] = mem_wdata;
            last_wr_addr = mem_addr;
            last_wr_bank = mem_bank;
        end
        if (mem_erase) begin
            int q[$];
            foreach (flash[i]) if (((i >> 16) & 1) == int'(mem_bank)) q.push_back(i);
            foreach (q[j]) flash.delete(q[j]);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run did not end act=hung exp=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    function automatic logic [7:0] model_get(input int bank, input int a);
        int k = (bank << 16) | a;
        return model.exists(k) ? model[k] : 8'hFF;
    endfunction

    // Load registers, enter idle, time busy, then wake (early or late).
    task automatic run_op(input logic [7:0] cmd, input logic [15:0] a, input logic [7:0] d,
                          input int exp_dur, input bit early_wake, input string req);
        int n = 0;
        wr_reg(2'd0, a[7:0]); wr_reg(2'd1, a[15:8]); wr_reg(2'd2, d); wr_reg(2'd3, cmd);
        @(negedge clk); idle_enter = 1'b1;
        @(negedge clk); idle_enter = 1'b0;
        if (early_wake) wake_req = 1'b1;
        while (busy && n < 1000) begin
            if (early_wake) check(idle_active == 1'b1, "R8 idle held while busy", idle_active, 1);
            n++; @(negedge clk);
        end
        check(n == exp_dur, {req, " busy length"}, n, exp_dur);
        check(idle_active == 1'b1, "R8 idle still set after busy", idle_active, 1);
        wake_req = 1'b1;
        @(negedge clk);
        check(idle_active == 1'b0, "R8 wake ends idle", idle_active, 0);
        wake_req = 1'b0;
    endtask

    task automatic do_read(input int bank, input logic [15:0] a, input int exp_dur,
                           output logic [7:0] v);
        run_op(bank ? 8'h40 : 8'h00, a, 8'h00, exp_dur, 1'b0, "R6 read");
        rd_reg(2'd2, v);
    endtask

    initial begin
        logic [7:0] v;
        int a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 0, "R1 busy", busy, 0);
        check(idle_active == 0, "R1 idle", idle_active, 0);
        for (int i = 0; i < 4; i++) begin
            rd_reg(2'(i), v); check(v == 8'h00, "R1 reg reset", v, 0);
        end
        // R2 write/readback
        wr_reg(2'd0, 8'hA5); wr_reg(2'd1, 8'h3C); wr_reg(2'd2, 8'h96); wr_reg(2'd3, 8'h7E);
        rd_reg(2'd0, v); check(v == 8'hA5, "R2 addr lo", v, 8'hA5);
        rd_reg(2'd1, v); check(v == 8'h3C, "R2 addr hi", v, 8'h3C);
        rd_reg(2'd2, v); check(v == 8'h96, "R2 data", v, 8'h96);
        rd_reg(2'd3, v); check(v == 8'h7E, "R2 cmd", v, 8'h7E);
        // R6 erased read, R3 timing
        do_read(0, 16'h1234, RC, v); check(v == 8'hFF, "R6 erased reads FF", v, 8'hFF);
        // R5 program then AND
        run_op(8'h21, 16'h1234, 8'h5A, PC, 1'b0, "R5 program");
        do_read(0, 16'h1234, RC, v); check(v == 8'h5A, "R5 program value", v, 8'h5A);
        run_op(8'h21, 16'h1234, 8'h0F, PC, 1'b1, "R5 program again");
        do_read(0, 16'h1234, RC, v); check(v == 8'h0A, "R5 bits only clear", v, 8'h0A);
        // R9 loader bank wrap
        run_op(8'h61, 16'hF123, 8'h33, PC, 1'b0, "R9 loader program");
        check(last_wr_addr == 16'h0123, "R9 loader address wrap", last_wr_addr, 16'h0123);
        check(last_wr_bank == 1'b1, "R9 loader bank select", last_wr_bank, 1);
        do_read(1, 16'h0123, RC, v); check(v == 8'h33, "R9 loader readback", v, 8'h33);
        do_read(0, 16'h0123, RC, v); check(v == 8'hFF, "R9 app bank untouched", v, 8'hFF);
        // R4 erase with R11 write during busy
        wr_reg(2'd2, 8'h11); wr_reg(2'd3, 8'h22);
        @(negedge clk); idle_enter = 1'b1;
        @(negedge clk); idle_enter = 1'b0;
        check(busy == 1'b1, "R3 erase busy", busy, 1);
        wr_reg(2'd2, 8'hEE);
        rd_reg(2'd2, v); check(v == 8'h11, "R11 write ignored while busy", v, 8'h11);
        while (busy) @(negedge clk);
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        do_read(0, 16'h1234, RC, v); check(v == 8'hFF, "R4 erased app", v, 8'hFF);
        do_read(1, 16'h0123, RC, v); check(v == 8'h33, "R4 loader survives erase", v, 8'h33);
        model[(1 << 16) | 16'h0123] = 8'h33;
        // R7 disabled and illegal commands
        a0 = acc_cnt; prog_en = 1'b0;
        run_op(8'h21, 16'h0200, 8'h00, 0, 1'b0, "R7 prog disabled");
        prog_en = 1'b1;
        run_op(8'h31, 16'h0200, 8'h00, 0, 1'b0, "R7 illegal chip enable");
        run_op(8'h01, 16'h0200, 8'h00, 0, 1'b0, "R7 read with wrong enable");
        rd_reg(2'd2, v); check(v == 8'h00, "R7 data reg unchanged", v, 0);
        check(acc_cnt == a0, "R7 no array access", acc_cnt, a0);
        do_read(0, 16'h0200, RC, v); check(v == 8'hFF, "R7 array unchanged", v, 8'hFF);
        // R10 lock
        run_op(8'h21, 16'h0300, 8'h77, PC, 1'b0, "R10 setup program");
        model[16'h0300] = 8'h77;
        a0 = acc_cnt; lock_n = 1'b0;
        do_read(0, 16'h0300, RC, v);
        check(v == 8'h00, "R10 locked read", v, 0);
        check(acc_cnt == a0, "R10 no access when locked", acc_cnt, a0);
        lock_n = 1'b1;
        // Random program/read mix against the bench model
        void'($urandom(32'h5EED));
        for (int t = 0; t < 40; t++) begin
            int bank = $urandom % 2;
            logic [15:0] a = 16'(($urandom % 6) * 16'h0111);
            logic [7:0]  d = 8'($urandom);
            int k = (bank << 16) | (bank ? (a & 16'h0FFF) : a);
            if ($urandom % 2) begin
                run_op(bank ? 8'h61 : 8'h21, a, d, PC, 1'($urandom), "R5 random program");
                model[k] = model_get(bank, k & 16'hFFFF) & d;
            end else begin
                do_read(bank, a, RC, v);
                check(v == model_get(bank, k & 16'hFFFF), "R6 random read", v,
                      model_get(bank, k & 16'hFFFF));
            end
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule